// File: doc/BRIEF.md
# Opcode-Snooping Bank Extension Unit

This unit sits next to an unmodified 8-bit processor and listens to its bus. It extends the processor's reach into a 1 MiB external SRAM through one 4 KiB window at $A000–$AFFF, and it needs no change to the processor. The bank is chosen inline by two three-byte opcodes that the processor already executes as harmless no-operations. The unit watches opcode fetches, spots these opcodes and captures their bank byte. Every access that falls in the window then gets the selected bank placed in front of its 12-bit offset.

There are two kinds of prefix. A data prefix ($FC) is one-shot: it sets the bank for the data accesses of the next instruction only. A jump prefix ($DC) is taken up by a following JMP or JSR, and it changes the execution bank persistently from the target's first opcode onward. A hardware stack of saved banks follows the processor's own call and interrupt nesting. JSR and interrupt entry push an entry; RTS and RTI pop one. Subroutines and interrupt handlers in banked memory therefore return to the bank they came from. A data prefix interrupted before its instruction ran is also saved, and it is re-armed after RTI.

Top module: `opsnoop_bank_mmu`

## Requirements
- R1: After reset the execution bank is 0 and no prefix is armed, so a non-fetch read of $A123 maps to $00123.
- R2: An address with upper nibble $A drives win_hit high and sram_addr = {bank[7:0], addr[11:0]}. Any other address drives win_hit low and sram_addr = {4'h0, addr}.
- R3: An opcode fetch (sync high, rw high) of $FC followed by two bytes arms a data bank. The second byte becomes the bank and the first byte is ignored. The bank applies to the non-fetch window accesses of the next instruction.
- R4: An armed data bank is dropped at the following opcode fetch, whether or not its instruction touched the window.
- R5: During the armed instruction, its opcode fetch and its two following addresses still use the execution bank.
- R6: An opcode fetch of $DC followed by two bytes records a jump bank (the second byte). If the next opcode is JMP ($4C) or JSR ($20), the execution bank becomes that bank from the next opcode fetch on and stays until changed. Any other next opcode discards the jump bank.
- R7: A JSR ($20) fetch pushes the execution bank. An RTS ($60) fetch pops it, and the popped bank takes effect at the next opcode fetch. Operand bytes of the JSR or RTS use the old bank.
- R8: The bank stack holds 128 entries and its pointer wraps modulo 128. A pop from the empty stack returns entry 127.
- R9: A rising edge of the vector-fetch input pushes the execution bank together with any armed data bank. It then sets the execution bank to 0 and drops the armed data bank.
- R10: An RTI ($40) fetch pops an entry. It restores the execution bank from the next opcode fetch, and it re-arms the saved data bank for the instruction fetched after RTI.
- R11: Prefix opcodes are recognised only on opcode fetch cycles; a $FC byte on a non-fetch cycle has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | One rising edge per processor bus cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | 16 | Processor address |
| cpu_data | input | 8 | Byte on the data bus this cycle |
| cpu_rw | input | 1 | High for a read cycle |
| cpu_sync | input | 1 | High during an opcode fetch cycle |
| cpu_vec | input | 1 | High while the interrupt vector is being read |
| sram_addr | output | 20 | Extended physical address |
| win_hit | output | 1 | The current address lies in the bank window |

## Verification
Assertions check on every cycle the things that are local to one step. A prefix's operand bytes follow in order. An armed data bank never survives a second opcode fetch. Interrupt entry leaves bank 0 with nothing armed. The stack pointer moves by exactly one per push and never pushes and pops at once. The bench scenarios are needed for the actual physical addresses, which bank wins for an instruction's own bytes, nested calls that unwind to the right bank, a prefix re-armed across an interrupt, and stack wrap.

// File: rtl/smmu_pkg.sv
`timescale 1ns/1ps
package smmu_pkg;
  localparam int BYTE_W = 8;
  localparam logic [BYTE_W-1:0] OPC_DPFX = 8'hFC;
  localparam logic [BYTE_W-1:0] OPC_JPFX = 8'hDC;
  localparam logic [BYTE_W-1:0] OPC_JSR  = 8'h20;
  localparam logic [BYTE_W-1:0] OPC_JMP  = 8'h4C;
  localparam logic [BYTE_W-1:0] OPC_RTS  = 8'h60;
  localparam logic [BYTE_W-1:0] OPC_RTI  = 8'h40;

  typedef enum logic [1:0] {PD_IDLE, PD_HI, PD_LO} pd_state_e;
endpackage

// File: rtl/smmu_pfx_decoder.sv
`timescale 1ns/1ps
module smmu_pfx_decoder
  import smmu_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fetch,
  input  logic [BYTE_W-1:0] bus_data,
  output logic              cap_o,
  output logic              jump_o
);
  pd_state_e state, state_n;
  logic      kind, kind_n;

  always_comb begin
    state_n = state;
    kind_n  = kind;
    if (fetch) begin
      if (bus_data == OPC_DPFX || bus_data == OPC_JPFX) begin
        state_n = PD_HI;
        kind_n  = (bus_data == OPC_JPFX);
      end else begin
        state_n = PD_IDLE;
      end
    end else begin
      case (state)
        PD_HI:   state_n = PD_LO;
        default: state_n = PD_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= PD_IDLE;
      kind  <= 1'b0;
    end else begin
      state <= state_n;
      kind  <= kind_n;
    end
  end

  // the bank byte is on the bus in the second operand cycle
  assign cap_o  = (state == PD_LO) && !fetch;
  assign jump_o = kind;

  // R3
  pfx_seq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == PD_HI && !fetch) |=> (state == PD_LO));
endmodule

// File: rtl/smmu_bank_stack.sv
`timescale 1ns/1ps
module smmu_bank_stack #(
  parameter int DEPTH = 128,
  parameter int ENT_W = 17
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic             pop,
  input  logic [ENT_W-1:0] wdata,
  output logic [ENT_W-1:0] rdata
);
  localparam int PTR_W = $clog2(DEPTH);

  logic [ENT_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0] sp, sp_n, top_idx;

  assign top_idx = sp - PTR_W'(1);
  assign rdata   = mem[top_idx];

  always_comb begin
    sp_n = sp;
    if (push)     sp_n = sp + PTR_W'(1);
    else if (pop) sp_n = top_idx;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sp <= '0;
    else        sp <= sp_n;
  end

  always_ff @(posedge clk) begin
    if (push) mem[sp] <= wdata;
  end

  // R8
  stk_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push |=> (sp == $past(sp) + PTR_W'(1)));
  // R8
  stk_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push) |=> (sp == $past(sp) - PTR_W'(1)));
  // R7
  stk_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(push && pop));
endmodule

// File: rtl/opsnoop_bank_mmu.sv
`timescale 1ns/1ps
module opsnoop_bank_mmu
  import smmu_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int OFS_W     = 12,
  parameter int BANK_W    = 8,
  parameter int STK_DEPTH = 128,
  parameter logic [ADDR_W-OFS_W-1:0] WIN_TAG = 'hA
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [ADDR_W-1:0]        cpu_addr,
  input  logic [BYTE_W-1:0]        cpu_data,
  input  logic                     cpu_rw,
  input  logic                     cpu_sync,
  input  logic                     cpu_vec,
  output logic [BANK_W+OFS_W-1:0]  sram_addr,
  output logic                     win_hit
);
  localparam int PHYS_W = BANK_W + OFS_W;
  localparam int ENT_W  = 2*BANK_W + 1;

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rsync;
  logic       rst_i_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync <= 2'b00;
    else        rsync <= {rsync[0], 1'b1};
  end
  assign rst_i_n = rsync[1];

  logic fetch, in_win, vec_rise;
  logic is_jsr, is_jmp, is_rts, is_rti, push, pop;
  logic dec_cap, dec_jump;
  logic [ENT_W-1:0] push_data, top_data;

  // state registers and their next values
  logic [BANK_W-1:0] exe_bank, exe_bank_n, exe_next, exe_next_n;
  logic              exe_ld, exe_ld_n;
  logic              pend_v, pend_v_n, act_v, act_v_n, jmp_v, jmp_v_n;
  logic [BANK_W-1:0] pend_b, pend_b_n, act_b, act_b_n, jmp_b, jmp_b_n;
  logic [ADDR_W-1:0] op_pc, op_pc_n, pc_dist;
  logic              vec_q;
  logic [BANK_W-1:0] exe_eff, win_bank;
  logic              own_byte;

  assign fetch    = cpu_sync & cpu_rw;
  assign in_win   = (cpu_addr[ADDR_W-1:OFS_W] == WIN_TAG);
  assign vec_rise = cpu_vec & ~vec_q;
  assign is_jsr   = fetch && (cpu_data == OPC_JSR);
  assign is_jmp   = fetch && (cpu_data == OPC_JMP);
  assign is_rts   = fetch && (cpu_data == OPC_RTS);
  assign is_rti   = fetch && (cpu_data == OPC_RTI);
  assign push     = is_jsr | vec_rise;
  assign pop      = is_rts | is_rti;
  assign exe_eff  = (fetch && exe_ld) ? exe_next : exe_bank;
  assign push_data = is_jsr ? {exe_eff, 1'b0, {BANK_W{1'b0}}}
                            : {exe_bank, act_v, act_b};

  smmu_pfx_decoder u_dec (
    .clk(clk), .rst_n(rst_i_n), .fetch(fetch), .bus_data(cpu_data),
    .cap_o(dec_cap), .jump_o(dec_jump)
  );

  smmu_bank_stack #(.DEPTH(STK_DEPTH), .ENT_W(ENT_W)) u_stk (
    .clk(clk), .rst_n(rst_i_n), .push(push), .pop(pop),
    .wdata(push_data), .rdata(top_data)
  );

  always_comb begin
    exe_bank_n = exe_bank;  exe_next_n = exe_next;  exe_ld_n = exe_ld;
    pend_v_n   = pend_v;    pend_b_n   = pend_b;
    act_v_n    = act_v;     act_b_n    = act_b;
    jmp_v_n    = jmp_v;     jmp_b_n    = jmp_b;
    op_pc_n    = op_pc;
    if (fetch) begin
      exe_bank_n = exe_eff;
      exe_ld_n   = 1'b0;
      act_v_n    = pend_v;
      act_b_n    = pend_b;
      pend_v_n   = 1'b0;
      jmp_v_n    = 1'b0;
      op_pc_n    = cpu_addr;
      if ((is_jsr || is_jmp) && jmp_v) begin
        exe_next_n = jmp_b;
        exe_ld_n   = 1'b1;
      end
      if (pop) begin
        exe_next_n = top_data[ENT_W-1 -: BANK_W];
        exe_ld_n   = 1'b1;
      end
      if (is_rti) begin
        pend_v_n = top_data[BANK_W];
        pend_b_n = top_data[BANK_W-1:0];
      end
    end
    if (dec_cap) begin
      if (dec_jump) begin jmp_v_n  = 1'b1; jmp_b_n  = cpu_data[BANK_W-1:0]; end
      else          begin pend_v_n = 1'b1; pend_b_n = cpu_data[BANK_W-1:0]; end
    end
    if (vec_rise) begin
      exe_bank_n = '0;
      exe_ld_n   = 1'b0;
      act_v_n    = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      exe_bank <= '0; exe_next <= '0; exe_ld <= 1'b0;
      pend_v   <= 1'b0; pend_b <= '0;
      act_v    <= 1'b0; act_b  <= '0;
      jmp_v    <= 1'b0; jmp_b  <= '0;
      op_pc    <= '0;   vec_q  <= 1'b0;
    end else begin
      exe_bank <= exe_bank_n; exe_next <= exe_next_n; exe_ld <= exe_ld_n;
      pend_v   <= pend_v_n;   pend_b   <= pend_b_n;
      act_v    <= act_v_n;    act_b    <= act_b_n;
      jmp_v    <= jmp_v_n;    jmp_b    <= jmp_b_n;
      op_pc    <= op_pc_n;    vec_q    <= cpu_vec;
    end
  end

  // the armed instruction's own three bytes stay in the execution bank
  assign pc_dist  = cpu_addr - op_pc;
  assign own_byte = (pc_dist < ADDR_W'(3));
  assign win_bank = fetch                  ? exe_eff :
                    (act_v && !own_byte)   ? act_b   : exe_bank;

  always_comb begin
    if (in_win) sram_addr = {win_bank, cpu_addr[OFS_W-1:0]};
    else        sram_addr = PHYS_W'(cpu_addr);
  end
  assign win_hit = in_win;

  // R4
  act_consumed_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    (act_v && fetch && !pend_v) |=> !act_v);
  // R9
  irq_entry_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    vec_rise |=> (exe_bank == '0 && !act_v && !exe_ld));
  // R6
  jmp_once_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    (fetch && !dec_cap) |=> !jmp_v);
endmodule

// File: tb/opsnoop_bank_mmu_test.sv
`timescale 1ns/1ps
module opsnoop_bank_mmu_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] cpu_addr;
  logic [7:0]  cpu_data;
  logic        cpu_rw, cpu_sync, cpu_vec;
  logic [19:0] sram_addr;
  logic        win_hit;

  int nchk = 0, nfail = 0;
  logic [19:0] got;
  logic        got_hit;
  bit          done = 1'b0;

  always #10 clk = ~clk;

  opsnoop_bank_mmu uut (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_data(cpu_data),
    .cpu_rw(cpu_rw), .cpu_sync(cpu_sync), .cpu_vec(cpu_vec),
    .sram_addr(sram_addr), .win_hit(win_hit)
  );

  task automatic bus(input logic [15:0] a, input logic [7:0] d,
                     input logic s, input logic v, input logic r);
    @(negedge clk);
    cpu_addr = a; cpu_data = d; cpu_sync = s; cpu_vec = v; cpu_rw = r;
    #2;
    got = sram_addr; got_hit = win_hit;
  endtask
  task automatic op(input logic [15:0] a, input logic [7:0] d); bus(a, d, 1'b1, 1'b0, 1'b1); endtask
  task automatic rd(input logic [15:0] a, input logic [7:0] d = 8'h00); bus(a, d, 1'b0, 1'b0, 1'b1); endtask
  task automatic wr(input logic [15:0] a); bus(a, 8'h00, 1'b0, 1'b0, 1'b0); endtask

  task automatic chk(input string tag, input logic [19:0] exp);
    nchk++;
    if (got !== exp) begin
      nfail++;
      $display("FAIL %s: sram_addr=%05h expected %05h", tag, got, exp);
    end
  endtask
  task automatic chk_hit(input string tag, input logic exp);
    nchk++;
    if (got_hit !== exp) begin
      nfail++;
      $display("FAIL %s: win_hit=%0b expected %0b", tag, got_hit, exp);
    end
  endtask

  task automatic pfx(input logic [15:0] pc, input logic [7:0] opc,
                     input logic [7:0] hi, input logic [7:0] lo);
    op(pc, opc); rd(pc + 16'd1, hi); rd(pc + 16'd2, lo);
  endtask
  task automatic jsr_seq(input logic [15:0] pc, input logic [7:0] tgt_hi);
    op(pc, 8'h20); rd(pc + 16'd1); rd(16'h01F0); wr(16'h01F0); wr(16'h01EF);
    rd(pc + 16'd2, tgt_hi);
  endtask
  task automatic rts_seq(input logic [15:0] pc);
    op(pc, 8'h60); rd(pc + 16'd1); rd(16'h01EF); rd(16'h01F0); rd(16'h01F1); rd(16'h01F2);
  endtask

  task automatic t_reset;
    rd(16'hA123); chk("R1 reset bank", 20'h00123); chk_hit("R1 window hit", 1'b1);
  endtask

  task automatic t_window;
    rd(16'hAFFF); chk("R2 window top", 20'h00FFF); chk_hit("R2 top hit", 1'b1);
    rd(16'h9FFF); chk("R2 below window", 20'h09FFF); chk_hit("R2 below miss", 1'b0);
    rd(16'hB000); chk("R2 above window", 20'h0B000); chk_hit("R2 above miss", 1'b0);
  endtask

  task automatic t_nonfetch;
    op(16'h2000, 8'hAD); rd(16'h2001, 8'hFC); rd(16'h2002, 8'h00); rd(16'h2003, 8'h44);
    op(16'h2004, 8'hAD); rd(16'h2005); rd(16'h2006, 8'hA1);
    rd(16'hA100); chk("R11 data-cycle FC ignored", 20'h00100);
  endtask

  task automatic t_data_pfx;
    pfx(16'h2010, 8'hFC, 8'h37, 8'h22);
    op(16'h2013, 8'hAD); rd(16'h2014); rd(16'h2015, 8'hA1);
    rd(16'hA100); chk("R3 data prefix low byte", 20'h22100);
    op(16'h2016, 8'hEA); rd(16'hA100); chk("R4 consumed after use", 20'h00100);
    pfx(16'h2020, 8'hFC, 8'h00, 8'h44);
    op(16'h2023, 8'hEA); rd(16'h2024);
    op(16'h2024, 8'hAD); rd(16'h2025); rd(16'h2026, 8'hA1);
    rd(16'hA100); chk("R4 consumed untouched", 20'h00100);
  endtask

  task automatic t_own_bytes;
    op(16'hA000, 8'hFC); chk("R5 prefix fetch", 20'h00000);
    rd(16'hA001, 8'h00); rd(16'hA002, 8'h22);
    op(16'hA003, 8'hAD); chk("R5 armed opcode fetch", 20'h00003);
    rd(16'hA004, 8'h00); chk("R5 armed operand", 20'h00004);
    rd(16'hA005, 8'hA1); chk("R5 armed operand 2", 20'h00005);
    rd(16'hA100); chk("R3 armed data in window", 20'h22100);
    op(16'hA006, 8'hEA); chk("R4 next fetch exe bank", 20'h00006);
  endtask

  task automatic t_call;
    pfx(16'h2030, 8'hDC, 8'h00, 8'h05);
    jsr_seq(16'h2033, 8'hA2);
    pfx(16'hA200, 8'hDC, 8'h00, 8'h09);
    chk("R6 first target bank", 20'h05202);
    jsr_seq(16'hA203, 8'hA4); chk("R7 JSR operand old bank", 20'h05205);
    op(16'hA400, 8'hEA); chk("R6 nested target", 20'h09400);
    rd(16'hA300); chk("R6 data in exec bank", 20'h09300);
    rts_seq(16'hA401);
    op(16'hA206, 8'hEA); chk("R7 RTS restores outer", 20'h05206);
    rts_seq(16'hA207);
    op(16'h2036, 8'hEA); rd(16'hA300); chk("R7 RTS restores bank 0", 20'h00300);
  endtask

  task automatic t_jmp;
    pfx(16'h2040, 8'hDC, 8'h00, 8'h07);
    op(16'h2043, 8'h4C); rd(16'h2044); rd(16'h2045, 8'hA0);
    op(16'hA000, 8'hEA); chk("R6 JMP target", 20'h07000);
    rd(16'hA001);
    op(16'hA001, 8'hAD); rd(16'hA002); rd(16'hA003);
    rd(16'hA010); chk("R6 bank persists", 20'h07010);
    pfx(16'hA004, 8'hDC, 8'h00, 8'h0B);
    op(16'hA007, 8'hAD); rd(16'hA008); rd(16'hA009);
    op(16'hA00A, 8'hEA); chk("R6 prefix without jump discarded", 20'h0700A);
  endtask

  task automatic t_irq;
    pfx(16'hA020, 8'hFC, 8'h00, 8'h33);
    op(16'hA023, 8'h8D); chk("R10 interrupted fetch", 20'h07023);
    rd(16'hA023); rd(16'hA023); wr(16'h01FF); wr(16'h01FE); wr(16'h01FD);
    bus(16'hFFFE, 8'h00, 1'b0, 1'b1, 1'b1);
    bus(16'hFFFF, 8'h30, 1'b0, 1'b1, 1'b1);
    op(16'h3000, 8'hAD); rd(16'h3001); rd(16'h3002, 8'hA1);
    rd(16'hA100); chk("R9 handler bank 0, prefix dropped", 20'h00100);
    op(16'h3003, 8'h40); rd(16'h3004);
    rd(16'h01FC); rd(16'h01FD); rd(16'h01FE); rd(16'h01FF);
    op(16'hA023, 8'h8D); chk("R10 exec bank restored", 20'h07023);
    rd(16'hA024); chk("R10 operand exec bank", 20'h07024);
    rd(16'hA025, 8'hA1);
    wr(16'hA100); chk("R10 prefix re-armed", 20'h33100);
    op(16'hA026, 8'hEA); rd(16'hA100); chk("R10 re-armed prefix consumed", 20'h07100);
  endtask

  task automatic t_stack;
    for (int i = 1; i <= 128; i++) begin
      pfx(16'h2000, 8'hDC, 8'h00, 8'(i));
      jsr_seq(16'h2003, 8'h20);
    end
    op(16'h2100, 8'hEA); rd(16'hA000); chk("R8 deepest bank", 20'h80000);
    for (int k = 0; k < 128; k++) begin
      rts_seq(16'h2101);
      op(16'h2110, 8'hEA); rd(16'hA000);
      chk("R8 unwind", (k == 127) ? 20'h07000 : {8'(127 - k), 12'h000});
    end
    rts_seq(16'h2101);
    op(16'h2110, 8'hEA); rd(16'hA000); chk("R8 pointer wraps", 20'h7F000);
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog: run did not complete");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cpu_addr = 16'h0000; cpu_data = 8'h00;
    cpu_rw = 1'b1; cpu_sync = 1'b0; cpu_vec = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_window();
    t_nonfetch();
    t_data_pfx();
    t_own_bytes();
    t_call();
    t_jmp();
    t_irq();
    t_stack();
    done = 1'b1;
    summary();
    $finish;
  end
endmodule